// File: doc/BRIEF.md
# Regulator Fault Protection Supervisor

This block sits between the fault comparators of a switching regulator and its power stage. Each comparator delivers a one-bit flag. The block qualifies each flag over a fault-specific persistence time, measured in microsecond ticks. When a fault qualifies, it drives the protective response: it tri-states the PWM output, forces the low-side switch on, pulls power-good low and raises a thermal alert. It also decides how a latched fault may be cleared, either by cycling the regulator's enable input or only by a supply-level reset.

Four faults are timed: overcurrent, severe overcurrent, relative overvoltage and undervoltage. Each has its own counter that restarts when its flag drops early. The absolute overvoltage fault acts at once. It first clamps the output through the low-side switch. When the output-below-release flag reports that the output has fallen far enough, it changes to the tri-stated, latched condition. From there only the supply reset (`rst`) recovers the block. The over-temperature flag only drives the alert output and has no effect on the power stage. The first fault to trip owns the latched state until that state is cleared.

Top module: `fault_supervisor`

## Requirements
- R1: While `rst` is high at a clock edge, all four outputs are 0 after that edge.
- R2: `enable_in` passes through a two-flop synchronizer. `pgood` is 1 only when no fault is latched or clamping and the synchronized enable is 1. It is 0 whenever the regulator is disabled.
- R3: An overcurrent flag held high for 120 consecutive ticks trips the soft latch. Fewer ticks leave the outputs unchanged.
- R4: A severe overcurrent flag held high for 2 ticks trips the soft latch.
- R5: A relative overvoltage flag or an undervoltage flag, each held high for 1000 ticks, trips the soft latch.
- R6: Dropping a timed flag before its limit restarts that fault's count from zero.
- R7: In the soft latch, `pwm_tristate` is 1 and `pgood` is 0. The state holds while enable stays high.
- R8: The soft latch clears when the synchronized enable is seen low and later high. The block then returns to normal running with fresh counts.
- R9: While running, an absolute overvoltage flag sets `lowside_on` to 1 after the next edge. In that case `pwm_tristate` is 0 and `pgood` is 0. Absolute overvoltage takes priority over a timed fault that qualifies in the same cycle.
- R10: During the clamp, the output-below-release flag clears `lowside_on` and sets `pwm_tristate` after the next edge. This enters the hard latch.
- R11: The hard latch ignores enable toggles and clears only through `rst`.
- R12: `therm_alert` follows the over-temperature flag one clock later. It never changes `pwm_tristate`, `lowside_on` or `pgood`.
- R13: While a latch is held, other fault flags, including absolute overvoltage, do not change the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high supply/power-on reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| enable_in | input | 1 | Regulator enable, asynchronous |
| flag_oc | input | 1 | Overcurrent comparator flag |
| flag_soc | input | 1 | Severe overcurrent comparator flag |
| flag_ov_abs | input | 1 | Absolute overvoltage comparator flag |
| flag_ov_rel | input | 1 | Relative overvoltage comparator flag |
| flag_uv | input | 1 | Undervoltage comparator flag |
| flag_ot | input | 1 | Over-temperature flag |
| flag_below | input | 1 | Output has fallen below the clamp release level |
| pwm_tristate | output | 1 | Tri-state the PWM output |
| lowside_on | output | 1 | Force the low-side switch on |
| pgood | output | 1 | Power-good |
| therm_alert | output | 1 | Thermal alert |

## Verification
The assertions check, on every cycle, the rules that can be read straight off the ports. The clamp and tri-state are never active together. Power-good is low whenever either protective output is active. The alert follows its flag with one clock of delay. An absolute overvoltage seen while running starts the clamp. The release flag ends the clamp in the tri-stated state. Reset clears all outputs. Other behaviour depends on long persistence windows and on history: the exact trip tick of each timed fault, a count restarting after a short glitch, the low-then-high enable sequence that clears the soft latch, and the hard latch refusing that same sequence. These can only be shown by the bench scenarios, checked against the cycle-by-cycle reference model.

// File: rtl/fault_sup_pkg.sv
package fault_sup_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_CLAMP = 2'd1,
    ST_SOFT  = 2'd2,
    ST_HARD  = 2'd3
  } sup_state_t;

  localparam int NUM_TIMED = 4;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fault_qual.sv
module fault_qual #(
  parameter int LIMIT = 120,
  parameter int W     = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic flag,
  input  logic tick,
  output logic qual
);
  localparam logic [W-1:0] LIM_V = W'(LIMIT);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr || !flag)           cnt <= '0;
    else if (tick && (cnt != LIM_V))   cnt <= cnt + 1'b1;
  end

  assign qual = (cnt == LIM_V);
endmodule

// File: rtl/fault_ctrl.sv
module fault_ctrl
  import fault_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en_s,
  input  logic       qual_any,
  input  logic       ov_abs,
  input  logic       below,
  input  logic       ot,
  output logic       running,
  output logic       tri_q,
  output logic       ls_q,
  output logic       pg_q,
  output logic       alert_q
);
  sup_state_t state_q, state_d;
  logic       seen_low_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:   if (ov_abs) state_d = ST_CLAMP;
                else if (qual_any) state_d = ST_SOFT;
      ST_CLAMP: if (below) state_d = ST_HARD;
      ST_SOFT:  if (seen_low_q && en_s) state_d = ST_RUN;
      ST_HARD:  state_d = ST_HARD;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_RUN;
      seen_low_q <= 1'b0;
      tri_q      <= 1'b0;
      ls_q       <= 1'b0;
      pg_q       <= 1'b0;
      alert_q    <= 1'b0;
    end else begin
      state_q    <= state_d;
      seen_low_q <= (state_q == ST_SOFT) && (seen_low_q || !en_s);
      tri_q      <= (state_d == ST_SOFT) || (state_d == ST_HARD);
      ls_q       <= (state_d == ST_CLAMP);
      pg_q       <= (state_d == ST_RUN) && en_s;
      alert_q    <= ot;
    end
  end

  assign running = (state_q == ST_RUN);
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fault_sup_pkg::*;
#(
  parameter int OC_US     = 120,
  parameter int SOC_US    = 2,
  parameter int OVREL_US  = 1000,
  parameter int UV_US     = 1000,
  parameter int SYNC_FF   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_us,
  input  logic enable_in,
  input  logic flag_oc,
  input  logic flag_soc,
  input  logic flag_ov_abs,
  input  logic flag_ov_rel,
  input  logic flag_uv,
  input  logic flag_ot,
  input  logic flag_below,
  output logic pwm_tristate,
  output logic lowside_on,
  output logic pgood,
  output logic therm_alert
);
  localparam int MAX_LIM = max_of(max_of(OC_US, SOC_US), max_of(OVREL_US, UV_US));
  localparam int CNT_W   = $clog2(MAX_LIM + 1);
  localparam int LIMS [NUM_TIMED] = '{OC_US, SOC_US, OVREL_US, UV_US};

  logic                 en_s;
  logic                 running;
  logic [NUM_TIMED-1:0] flags;
  logic [NUM_TIMED-1:0] qual;

  assign flags = {flag_uv, flag_ov_rel, flag_soc, flag_oc};

  fault_sync #(.STAGES(SYNC_FF)) u_en_sync (
    .clk (clk),
    .rst (rst),
    .d   (enable_in),
    .q   (en_s)
  );

  for (genvar g = 0; g < NUM_TIMED; g++) begin : g_qual
    fault_qual #(.LIMIT(LIMS[g]), .W(CNT_W)) u_qual (
      .clk  (clk),
      .rst  (rst),
      .clr  (!running),
      .flag (flags[g]),
      .tick (tick_us),
      .qual (qual[g])
    );
  end

  fault_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .en_s     (en_s),
    .qual_any (|qual),
    .ov_abs   (flag_ov_abs),
    .below    (flag_below),
    .ot       (flag_ot),
    .running  (running),
    .tri_q    (pwm_tristate),
    .ls_q     (lowside_on),
    .pg_q     (pgood),
    .alert_q  (therm_alert)
  );
endmodule

// File: rtl/fault_supervisor_chk.sv
module fault_supervisor_chk (
  input logic clk,
  input logic rst,
  input logic flag_ov_abs,
  input logic flag_ot,
  input logic flag_below,
  input logic pwm_tristate,
  input logic lowside_on,
  input logic pgood,
  input logic therm_alert
);
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (!pwm_tristate && !lowside_on && !pgood && !therm_alert));

  p_pgood_off_when_protecting_r2: assert property (@(posedge clk) disable iff (rst)
    (pwm_tristate || lowside_on) |-> !pgood);

  p_clamp_starts_r9: assert property (@(posedge clk) disable iff (rst)
    (!pwm_tristate && !lowside_on && flag_ov_abs) |=> (lowside_on && !pwm_tristate));

  p_clamp_tristate_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(pwm_tristate && lowside_on));

  p_clamp_release_r10: assert property (@(posedge clk) disable iff (rst)
    (lowside_on && flag_below) |=> (!lowside_on && pwm_tristate));

  p_alert_follows_r12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (therm_alert == $past(flag_ot)));
endmodule

bind fault_supervisor fault_supervisor_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .flag_ov_abs  (flag_ov_abs),
  .flag_ot      (flag_ot),
  .flag_below   (flag_below),
  .pwm_tristate (pwm_tristate),
  .lowside_on   (lowside_on),
  .pgood        (pgood),
  .therm_alert  (therm_alert)
);

// File: tb/test_fault_supervisor.sv
`timescale 1ns/1ps
module test_fault_supervisor;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, tick_us = 1'b0, enable_in = 1'b0;
  logic flag_oc = 0, flag_soc = 0, flag_ov_abs = 0, flag_ov_rel = 0;
  logic flag_uv = 0, flag_ot = 0, flag_below = 0;
  logic pwm_tristate, lowside_on, pgood, therm_alert;

  fault_supervisor i_fault_supervisor (
    .clk(clk), .rst(rst), .tick_us(tick_us), .enable_in(enable_in),
    .flag_oc(flag_oc), .flag_soc(flag_soc), .flag_ov_abs(flag_ov_abs),
    .flag_ov_rel(flag_ov_rel), .flag_uv(flag_uv), .flag_ot(flag_ot),
    .flag_below(flag_below), .pwm_tristate(pwm_tristate),
    .lowside_on(lowside_on), .pgood(pgood), .therm_alert(therm_alert)
  );

  int checks = 0, errors = 0;
  bit cmp_on = 0, done = 0;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: 0 run, 1 clamp, 2 soft latch, 3 hard latch
  int  lim [4] = '{120, 2, 1000, 1000};
  int  m_c [4];
  int  m_st = 0;
  bit  m_en1, m_en2, m_seen;
  bit  e_tri, e_ls, e_pg, e_ot;

  always @(posedge clk) begin
    bit fl [4];
    bit q;
    int ns;
    bit nseen;
    fl = '{flag_oc, flag_soc, flag_ov_rel, flag_uv};
    if (rst) begin
      foreach (m_c[i]) m_c[i] = 0;
      m_st = 0; m_en1 = 0; m_en2 = 0; m_seen = 0;
      e_tri = 0; e_ls = 0; e_pg = 0; e_ot = 0;
    end else begin
      q = 0;
      foreach (m_c[i]) if (m_c[i] == lim[i]) q = 1;
      ns = m_st;
      if (m_st == 0) begin
        if (flag_ov_abs) ns = 1; else if (q) ns = 2;
      end else if (m_st == 1) begin
        if (flag_below) ns = 3;
      end else if (m_st == 2) begin
        if (m_seen && m_en2) ns = 0;
      end
      nseen = (m_st == 2) && (m_seen || !m_en2);
      foreach (m_c[i]) begin
        if (m_st != 0 || !fl[i]) m_c[i] = 0;
        else if (tick_us && m_c[i] < lim[i]) m_c[i] = m_c[i] + 1;
      end
      e_tri = (ns == 2) || (ns == 3);
      e_ls  = (ns == 1);
      e_pg  = (ns == 0) && m_en2;
      e_ot  = flag_ot;
      m_en2 = m_en1; m_en1 = enable_in;
      m_st = ns; m_seen = nseen;
    end
  end

  always @(negedge clk) begin
    tick_us <= ~tick_us;
    if (cmp_on) begin
      chk("R7 tristate vs model", pwm_tristate, e_tri);
      chk("R9 lowside vs model", lowside_on, e_ls);
      chk("R2 pgood vs model", pgood, e_pg);
      chk("R12 alert vs model", therm_alert, e_ot);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle_en();
    enable_in = 0; cyc(5);
    enable_in = 1; cyc(6);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(4);
    cmp_on = 1;
    chk("R1 tristate after reset", pwm_tristate, 0);
    chk("R1 lowside after reset", lowside_on, 0);
    chk("R1 pgood after reset", pgood, 0);
    rst = 0;
    enable_in = 1; cyc(4);
    chk("R2 pgood when enabled", pgood, 1);
    enable_in = 0; cyc(4);
    chk("R2 pgood when disabled", pgood, 0);
    enable_in = 1; cyc(4);
    // R12
    flag_ot = 1; cyc(2);
    chk("R12 alert high", therm_alert, 1);
    chk("R12 no tristate", pwm_tristate, 0);
    chk("R12 pgood kept", pgood, 1);
    flag_ot = 0; cyc(2);
    // R6 then R3
    flag_oc = 1; cyc(200);
    flag_oc = 0; cyc(2);
    flag_oc = 1; cyc(200);
    chk("R6 restart count", pwm_tristate, 0);
    cyc(100);
    chk("R3 overcurrent trip", pwm_tristate, 1);
    chk("R7 pgood low", pgood, 0);
    flag_oc = 0;
    // R13
    flag_ov_abs = 1; cyc(3);
    chk("R13 ovabs ignored when latched", lowside_on, 0);
    flag_ov_abs = 0; cyc(10);
    chk("R7 latch held", pwm_tristate, 1);
    // R8
    toggle_en();
    chk("R8 soft latch cleared", pwm_tristate, 0);
    chk("R8 pgood restored", pgood, 1);
    // R4
    flag_soc = 1; cyc(2);
    chk("R4 not yet", pwm_tristate, 0);
    cyc(6);
    chk("R4 severe trip", pwm_tristate, 1);
    flag_soc = 0;
    toggle_en();
    // R5 undervoltage
    flag_uv = 1; cyc(1990);
    chk("R5 uv before limit", pwm_tristate, 0);
    cyc(30);
    chk("R5 uv trip", pwm_tristate, 1);
    flag_uv = 0;
    toggle_en();
    flag_ov_rel = 1; cyc(2030);
    chk("R5 ovrel trip", pwm_tristate, 1);
    flag_ov_rel = 0;
    toggle_en();
    // R9 / R10
    flag_ov_abs = 1; cyc(2);
    chk("R9 clamp on", lowside_on, 1);
    chk("R9 no tristate in clamp", pwm_tristate, 0);
    chk("R9 pgood low", pgood, 0);
    flag_ov_abs = 0; cyc(5);
    chk("R9 clamp held", lowside_on, 1);
    flag_below = 1; cyc(2);
    chk("R10 clamp released", lowside_on, 0);
    chk("R10 tristate", pwm_tristate, 1);
    flag_below = 0;
    // R11
    toggle_en();
    chk("R11 hard latch ignores enable", pwm_tristate, 1);
    rst = 1; cyc(2);
    rst = 0; cyc(4);
    chk("R11 cleared by reset", pwm_tristate, 0);
    chk("R11 pgood after reset", pgood, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule